// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block manages low-power states for a small processor subsystem. A bus master writes a 4-bit mode word (a sleep-enable flag plus a 3-bit mode code) and a per-pin input-disable mask. A single-cycle sleep request stands in for the processor's sleep instruction. If sleep is enabled and the mode code is legal, the controller moves to the selected low-power state. From that state it drives the enables for four clock domains (CPU, I/O, ADC, main oscillator) and for each pin's digital input buffer.

A wake pulse ends the sleep state. The I/O, ADC and oscillator enables return first, and the CPU clock follows one cycle later. While the I/O and ADC clocks are both stopped, only the pins named by a wake-pin mask keep their input buffers on. A debug-enable input keeps the oscillator running in every state.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, the status is 0 (active), all four clock enables are 1 and every input buffer enable is 1.
- R2: With reg_sel = 0, bits 3:0 of the mode register are readable and writable, with bit 0 = sleep enable and bits 3:1 = mode code. Bits 7:4 always read 0, and writes to them have no effect. With reg_sel = 1, the input-disable mask reads back as written, one bit per pin.
- R3: A sleep request made while sleep enable is 0 is ignored, and the status stays 0.
- R4: A sleep request with sleep enable set and mode code 011, 100, 101 or 111 is ignored, and the status stays 0.
- R5: Mode code 000 (light sleep) sets status 1. Only the CPU clock is stopped.
- R6: Mode code 001 (converter-quiet sleep) sets status 2. The CPU and I/O clocks are stopped, and the ADC clock and oscillator keep running.
- R7: Mode code 010 (deep sleep) sets status 3. The CPU, I/O and ADC clocks and the oscillator are all stopped.
- R8: Mode code 110 (fast-resume sleep) sets status 4. The CPU, I/O and ADC clocks are stopped, and the oscillator keeps running.
- R9: While the I/O and ADC clocks are both off, a pin's input buffer is enabled only if its wake_pin_mask bit is 1. Otherwise every buffer not masked off by R10 is enabled.
- R10: A pin whose input-disable mask bit is 1 has its input buffer enable at 0 in every state, including active.
- R11: While dbg_en is 1, osc_en is 1 in every state.
- R12: A wake pulse in any sleep state moves the controller to status 5 for exactly one cycle, with CPU off and I/O, ADC and oscillator on. The controller then moves to status 0 with all clocks on. A sleep request is honoured only in status 0.
- R13: The status output is 0 active, 1 light, 2 converter-quiet, 3 deep, 4 fast-resume, 5 resuming. The CPU clock enable is 1 only in status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the input-disable mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sleep_req | input | 1 | Sleep request pulse |
| wake | input | 1 | Wake pulse |
| dbg_en | input | 1 | Debug enable; keeps the oscillator on |
| wake_pin_mask | input | 8 | Pins that keep their input buffers in the deepest states |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| inbuf_en | output | 8 | Per-pin digital input buffer enable |
| mode_status | output | 3 | Current state code |

## Verification
The state register is one hot in its effect. A wrong state shows in the same cycle as a wrong status code and a wrong pattern across the four clock enables. A state transition taken or missed in error shows one cycle after the sleep request or wake pulse that caused it. A lost resume step shows as the CPU enable rising together with the other enables instead of one cycle later. A mask bit stored wrongly shows at once on inbuf_en, in active mode as well as in sleep.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_LIGHT  = 3'd1,
      ST_QUIET  = 3'd2,
      ST_DEEP   = 3'd3,
      ST_FAST   = 3'd4,
      ST_RESUME = 3'd5
   } pwr_state_e;

   localparam logic [2:0] CODE_LIGHT = 3'b000;
   localparam logic [2:0] CODE_QUIET = 3'b001;
   localparam logic [2:0] CODE_DEEP  = 3'b010;
   localparam logic [2:0] CODE_FAST  = 3'b110;

   typedef struct packed {
      logic cpu;
      logic io;
      logic adc;
      logic osc;
   } clk_en_t;

   function automatic logic code_reserved(input logic [2:0] c);
      return !(c == CODE_LIGHT || c == CODE_QUIET || c == CODE_DEEP || c == CODE_FAST);
   endfunction

endpackage

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs #(
   parameter int DATA_W   = 8,
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                sel,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                se,
   output logic [2:0]          sm,
   output logic [NUM_PINS-1:0] didr
);
   localparam int MODE_BITS = 4;

   initial begin
      assert (DATA_W >= MODE_BITS) else $error("DATA_W too small for mode word");
      assert (NUM_PINS <= DATA_W)  else $error("NUM_PINS exceeds DATA_W");
   end

   logic [MODE_BITS-1:0] mode_q;
   logic [NUM_PINS-1:0]  mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         mask_q <= '0;
      end else if (wr) begin
         if (sel) mask_q <= wdata[NUM_PINS-1:0];
         else     mode_q <= wdata[MODE_BITS-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) rdata[NUM_PINS-1:0]  = mask_q;
      else     rdata[MODE_BITS-1:0] = mode_q;
   end

   assign se   = mode_q[0];
   assign sm   = mode_q[3:1];
   assign didr = mask_q;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_pkg::*;
#(
   parameter int CPU_RESTART_LAG = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       wake,
   input  logic       se,
   input  logic [2:0] sm,
   output pwr_state_e state
);
   initial begin
      assert (CPU_RESTART_LAG == 0 || CPU_RESTART_LAG == 1)
         else $error("CPU_RESTART_LAG must be 0 or 1");
   end

   pwr_state_e wake_tgt;
   pwr_state_e state_d;

   generate
      if (CPU_RESTART_LAG != 0) begin : g_lag
         assign wake_tgt = ST_RESUME;
      end else begin : g_nolag
         assign wake_tgt = ST_ACTIVE;
      end
   endgenerate

   always_comb begin
      state_d = state;
      unique case (state)
         ST_ACTIVE: begin
            if (sleep_req && se && !code_reserved(sm)) begin
               unique case (sm)
                  CODE_LIGHT: state_d = ST_LIGHT;
                  CODE_QUIET: state_d = ST_QUIET;
                  CODE_DEEP:  state_d = ST_DEEP;
                  default:    state_d = ST_FAST;
               endcase
            end
         end
         ST_LIGHT, ST_QUIET, ST_DEEP, ST_FAST: begin
            if (wake) state_d = wake_tgt;
         end
         ST_RESUME: state_d = ST_ACTIVE;
         default:   state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_ACTIVE;
      else        state <= state_d;
   end
endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
   import pwr_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  pwr_state_e          state,
   input  logic                dbg_en,
   input  logic [NUM_PINS-1:0] wake_pin_mask,
   input  logic [NUM_PINS-1:0] didr,
   output clk_en_t             en,
   output logic [NUM_PINS-1:0] inbuf_en
);
   clk_en_t base;

   always_comb begin
      unique case (state)
         ST_ACTIVE: base = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
         ST_LIGHT:  base = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
         ST_QUIET:  base = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
         ST_DEEP:   base = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
         ST_FAST:   base = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
         ST_RESUME: base = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
         default:   base = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
      endcase
      en     = base;
      en.osc = base.osc | dbg_en;
   end

   logic any_clk;
   assign any_clk = base.io | base.adc;

   genvar p;
   generate
      for (p = 0; p < NUM_PINS; p++) begin : g_pin
         assign inbuf_en[p] = !didr[p] && (any_clk || wake_pin_mask[p]);
      end
   endgenerate
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
   import pwr_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int NUM_PINS        = 8,
   parameter int CPU_RESTART_LAG = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_sel,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                sleep_req,
   input  logic                wake,
   input  logic                dbg_en,
   input  logic [NUM_PINS-1:0] wake_pin_mask,
   output logic                cpu_clk_en,
   output logic                io_clk_en,
   output logic                adc_clk_en,
   output logic                osc_en,
   output logic [NUM_PINS-1:0] inbuf_en,
   output logic [2:0]          mode_status
);
   logic                ctl_se;
   logic [2:0]          ctl_sm;
   logic [NUM_PINS-1:0] ctl_didr;
   pwr_state_e          cur_state;
   clk_en_t             gate_en;

   pwr_ctl_regs #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .se    (ctl_se),
      .sm    (ctl_sm),
      .didr  (ctl_didr)
   );

   pwr_mode_fsm #(.CPU_RESTART_LAG(CPU_RESTART_LAG)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .wake      (wake),
      .se        (ctl_se),
      .sm        (ctl_sm),
      .state     (cur_state)
   );

   pwr_gate_decode #(.NUM_PINS(NUM_PINS)) u_gate (
      .state         (cur_state),
      .dbg_en        (dbg_en),
      .wake_pin_mask (wake_pin_mask),
      .didr          (ctl_didr),
      .en            (gate_en),
      .inbuf_en      (inbuf_en)
   );

   assign cpu_clk_en  = gate_en.cpu;
   assign io_clk_en   = gate_en.io;
   assign adc_clk_en  = gate_en.adc;
   assign osc_en      = gate_en.osc;
   assign mode_status = cur_state;
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk
   import pwr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sleep_req,
   input logic                dbg_en,
   input logic                reg_sel,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic                cpu_clk_en,
   input logic                io_clk_en,
   input logic                adc_clk_en,
   input logic                osc_en,
   input logic [NUM_PINS-1:0] inbuf_en,
   input logic [2:0]          mode_status,
   input logic                ctl_se,
   input logic [2:0]          ctl_sm,
   input logic [NUM_PINS-1:0] ctl_didr
);
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> reg_rdata[DATA_W-1:4] == '0); // R2

   AST_SE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'd0 && sleep_req && !ctl_se) |=> mode_status == 3'd0); // R3

   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'd0 && sleep_req && ctl_se && code_reserved(ctl_sm)) |=> mode_status == 3'd0); // R4

   AST_DEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      mode_status == 3'd3 |-> !cpu_clk_en && !io_clk_en && !adc_clk_en); // R7

   AST_MASK_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (inbuf_en & ctl_didr) == '0); // R10

   AST_DEBUG_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_en |-> osc_en); // R11

   AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_status == 3'd5 |=> mode_status == 3'd0 && cpu_clk_en); // R12

   AST_CPU_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> $past(io_clk_en) && $past(adc_clk_en) && $past(osc_en)); // R12

   AST_CPU_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> mode_status == 3'd0); // R13
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_req   (sleep_req),
   .dbg_en      (dbg_en),
   .reg_sel     (reg_sel),
   .reg_rdata   (reg_rdata),
   .cpu_clk_en  (cpu_clk_en),
   .io_clk_en   (io_clk_en),
   .adc_clk_en  (adc_clk_en),
   .osc_en      (osc_en),
   .inbuf_en    (inbuf_en),
   .mode_status (mode_status),
   .ctl_se      (ctl_se),
   .ctl_sm      (ctl_sm),
   .ctl_didr    (ctl_didr)
);

// File: tb/sim_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_sleep_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       sleep_req = 1'b0, wake = 1'b0, dbg_en = 1'b0;
   logic [7:0] wake_pin_mask = 8'h0F;
   logic       cpu_clk_en, io_clk_en, adc_clk_en, osc_en;
   logic [7:0] inbuf_en;
   logic [2:0] mode_status;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_sleep_ctrl u0 (.*);

   // vector: mode code[12:10], expected status[9:7], cpu,io,adc,osc [6:3], tag [2:0]
   localparam logic [12:0] VEC [8] = '{
      {3'b000, 3'd1, 4'b0111, 3'd5},
      {3'b001, 3'd2, 4'b0011, 3'd6},
      {3'b010, 3'd3, 4'b0000, 3'd7},
      {3'b011, 3'd0, 4'b1111, 3'd4},
      {3'b100, 3'd0, 4'b1111, 3'd4},
      {3'b101, 3'd0, 4'b1111, 3'd4},
      {3'b110, 3'd4, 4'b0001, 3'd0},
      {3'b111, 3'd0, 4'b1111, 3'd4}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic pulse_sleep;
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
   endtask

   task automatic pulse_wake;
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
   endtask

   function automatic logic [3:0] clks();
      return {cpu_clk_en, io_clk_en, adc_clk_en, osc_en};
   endfunction

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", mode_status, 3'd0);
      chk("R1 clocks", clks(), 4'b1111);
      chk("R1 inbuf", inbuf_en, 8'hFF);
      chk("R1 mode reg", reg_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      reg_sel = 1'b1; #0.1;
      chk("R1 mask reg", reg_rdata, 8'h00);

      // table walk
      for (int i = 0; i < 8; i++) begin
         logic [2:0] code = VEC[i][12:10];
         logic [2:0] st   = VEC[i][9:7];
         logic [3:0] ce   = VEC[i][6:3];
         logic [7:0] ib   = (ce[2] | ce[1]) ? 8'hFF : wake_pin_mask;
         string tag = (st == 3'd0) ? "R4" : (code == 3'b000) ? "R5" :
                      (code == 3'b001) ? "R6" : (code == 3'b010) ? "R7" : "R8";
         wr_reg(1'b0, {4'b0, code, 1'b1});
         pulse_sleep();
         chk({tag, " status"}, mode_status, st);
         chk({tag, " clocks"}, clks(), ce);
         chk("R9 inbuf", inbuf_en, ib);
         if (st != 3'd0) begin
            pulse_wake();
            chk("R12 resume status", mode_status, 3'd5);
            chk("R12 resume clocks", clks(), 4'b0111);
            @(negedge clk);
            chk("R12 active status", mode_status, 3'd0);
            chk("R13 cpu on", clks(), 4'b1111);
         end
      end

      // R2 upper bits ignored
      wr_reg(1'b0, 8'hFF);
      reg_sel = 1'b0; #0.1;
      chk("R2 upper bits", reg_rdata, 8'h0F);
      wr_reg(1'b1, 8'hA5);
      reg_sel = 1'b1; #0.1;
      chk("R2 mask readback", reg_rdata, 8'hA5);
      wr_reg(1'b1, 8'h00);

      // R3 SE clear: deep sleep code without enable
      wr_reg(1'b0, 8'h04);
      pulse_sleep();
      chk("R3 ignored", mode_status, 3'd0);
      chk("R3 clocks", clks(), 4'b1111);

      // R10 mask in active and in deep sleep
      wr_reg(1'b1, 8'h81);
      chk("R10 active", inbuf_en, 8'h7E);
      wr_reg(1'b0, 8'h05);
      pulse_sleep();
      chk("R7 deep status", mode_status, 3'd3);
      chk("R10 deep", inbuf_en, 8'h0E);
      // R11 debug keeps oscillator on
      dbg_en = 1'b1; #0.1;
      chk("R11 deep osc", osc_en, 1'b1);
      chk("R11 deep others", clks(), 4'b0001);
      // R12 sleep request ignored while asleep
      pulse_sleep();
      chk("R12 no re-entry", mode_status, 3'd3);
      pulse_wake();
      chk("R12 resume", mode_status, 3'd5);
      @(negedge clk);
      dbg_en = 1'b0;
      // R12 wake ignored while active
      pulse_wake();
      chk("R12 wake in active", mode_status, 3'd0);
      // R9 different wake mask in fast-resume sleep
      wr_reg(1'b1, 8'h00);
      wake_pin_mask = 8'hC3;
      wr_reg(1'b0, 8'h0D);
      pulse_sleep();
      chk("R8 fast status", mode_status, 3'd4);
      chk("R9 wake mask", inbuf_en, 8'hC3);
      pulse_wake();
      @(negedge clk);
      chk("R13 back active", mode_status, 3'd0);

      done = 1'b1;
      summary();
   end
endmodule